// File: doc/BRIEF.md
# Signed Integer to Double Converter

This block turns a 64-bit two's-complement integer into an IEEE-754 binary64 value. The rounding direction is chosen per operation by a 2-bit input. Along with the value it produces the update values a floating-point unit needs for its status register: a 5-bit result-class code, an inexact flag, an exception-summary flag and, when the record flag is set, a 4-bit condition nibble.

An operation is started by holding `in_valid` high for one cycle, with the operand, rounding mode and record flag on the same clock edge. The results, marked by `out_valid`, appear exactly one clock edge later. A new operation may be issued every cycle.

Fetch, decode, register files and the architectural status register are outside this block. The surrounding pipeline decides how the reported values are merged into that register. `rst_n` is asserted asynchronously and must be released in step with `clk`.

Top module: `int2dbl_conv`

## Requirements
- R1: The 64 input bits are read as a signed integer. The result is its binary64 value: sign in bit 63, biased exponent (bias 1023) in bits 62:52 and fraction in bits 51:0.
- R2: Any operand whose magnitude is at most 2^53 converts exactly, with `out_xx` and `out_fx` both 0, whatever the rounding mode.
- R3: When the conversion discards nonzero low-order bits, `out_xx` (inexact) and `out_fx` (exception summary) are both 1. Otherwise both are 0.
- R4: Rounding mode code 00 rounds to nearest with ties to even, 01 rounds toward zero, 10 toward plus infinity, and 11 toward minus infinity.
- R5: When rounding up carries out of the 53-bit significand, the exponent is increased by one and the fraction becomes zero. For example, 2^63-1 rounded to nearest gives 2^63.
- R6: The most negative operand, -2^63, converts exactly to 0xC3E0000000000000 in every rounding mode.
- R7: A zero operand gives +0.0 (all 64 bits zero) and class code 5'b00010.
- R8: A positive nonzero result gives class code 5'b00100 and a negative result gives 5'b01000. No other class codes occur.
- R9: The exponent field is never all ones: every result is finite.
- R10: With the record flag set, `out_cr` is {FX, FEX, VX, OX} from bit 3 down to bit 0. Here FX equals `out_fx`, and FEX, VX and OX are 0. With the record flag clear, `out_cr` is 4'b0000.
- R11: `out_valid` is high exactly on the cycle after each cycle in which `in_valid` was high, and low otherwise.
- R12: While reset is asserted, and until the first operation, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 64 | Signed integer operand |
| in_rmode | input | 2 | Rounding mode code |
| in_rec | input | 1 | Record flag: request the condition nibble |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_result | output | 64 | binary64 result |
| out_class | output | 5 | Result-class code |
| out_xx | output | 1 | Inexact indication |
| out_fx | output | 1 | Exception-summary indication |
| out_cr | output | 4 | Condition nibble {FX, FEX, VX, OX} |

## Verification
Every result field, including the class code, the two flags and the condition nibble, is due exactly one clock edge after the edge that sampled `in_valid`. The driver applies each operation on a falling edge and queues the expected item, computed with a reference model that uses only integer shifts and comparisons. The monitor samples on the next falling edge, half a cycle after the registering edge. It pops one item for every `out_valid`. It also checks that `out_valid` matches the `in_valid` captured at the previous rising edge, so a result that arrives late or is missing is flagged even if the values would still match in order.

// File: rtl/i2d_pkg.sv
package i2d_pkg;
  parameter int INT_W  = 64;
  parameter int EXP_W  = 11;
  parameter int FRAC_W = 52;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int LZC_W  = $clog2(INT_W);
  localparam int GRD_POS = INT_W - SIG_W - 1;
  localparam int CLS_W  = 5;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_ZERO = 2'b01,
    RND_PINF = 2'b10,
    RND_NINF = 2'b11
  } rnd_mode_e;

  localparam logic [CLS_W-1:0] CLS_PZERO = 5'b00010;
  localparam logic [CLS_W-1:0] CLS_PNORM = 5'b00100;
  localparam logic [CLS_W-1:0] CLS_NNORM = 5'b01000;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] expo;
    logic [FRAC_W-1:0] frac;
  } dbl_t;
endpackage

// File: rtl/i2d_mag.sv
module i2d_mag
  import i2d_pkg::*;
(
  input  logic [INT_W-1:0] op,
  output logic             sign,
  output logic [INT_W-1:0] mag
);
  // Unsigned view of the negation keeps -2^63 as 0x8000... without overflow
  always_comb begin
    sign = op[INT_W-1];
    mag  = sign ? (~op + INT_W'(1)) : op;
  end
endmodule

// File: rtl/i2d_lzc.sv
module i2d_lzc #(
  parameter int W  = 64,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0] val,
  output logic [CW:0]  cnt
);
  logic [W-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_hit
      assign hit[g] = val[g];
    end
  endgenerate

  // Scanning upward: the last set bit seen is the most significant one
  always_comb begin
    cnt = (CW+1)'(W);
    for (int i = 0; i < W; i++) begin
      if (hit[i]) cnt = (CW+1)'(W - 1 - i);
    end
  end
endmodule

// File: rtl/i2d_round.sv
module i2d_round
  import i2d_pkg::*;
(
  input  logic             sign,
  input  logic [INT_W-1:0] mag,
  input  logic [LZC_W:0]   lz,
  input  logic [1:0]       rmode,
  output dbl_t             res,
  output logic             inexact,
  output logic             is_zero
);
  logic [INT_W-1:0] norm;
  logic [SIG_W-1:0] mant;
  logic             guard;
  logic             sticky;
  logic             up;
  logic [SIG_W:0]   mant_up;
  logic             carry;
  logic [EXP_W-1:0] exp_base;

  always_comb begin
    is_zero  = (mag == '0);
    norm     = mag << lz[LZC_W-1:0];
    mant     = norm[INT_W-1 -: SIG_W];
    guard    = norm[GRD_POS];
    sticky   = |norm[GRD_POS-1:0];
    inexact  = !is_zero && (guard || sticky);

    unique case (rnd_mode_e'(rmode))
      RND_NEAR: up = guard && (sticky || mant[0]);
      RND_ZERO: up = 1'b0;
      RND_PINF: up = inexact && !sign;
      RND_NINF: up = inexact && sign;
      default:  up = 1'b0;
    endcase

    mant_up  = {1'b0, mant} + (SIG_W+1)'(up);
    carry    = mant_up[SIG_W];
    exp_base = EXP_W'(BIAS + INT_W - 1) - EXP_W'(lz);

    if (is_zero) begin
      res = '0;
    end else begin
      res.sign = sign;
      res.expo = exp_base + EXP_W'(carry);
      res.frac = mant_up[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/int2dbl_conv.sv
module int2dbl_conv
  import i2d_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [INT_W-1:0]   in_op,
  input  logic [1:0]         in_rmode,
  input  logic               in_rec,
  output logic               out_valid,
  output logic [INT_W-1:0]   out_result,
  output logic [CLS_W-1:0]   out_class,
  output logic               out_xx,
  output logic               out_fx,
  output logic [3:0]         out_cr
);
  logic             op_sign;
  logic [INT_W-1:0] op_mag;
  logic [LZC_W:0]   op_lz;
  dbl_t             rnd_res;
  logic             rnd_inexact;
  logic             rnd_zero;

  i2d_mag u_mag (
    .op   (in_op),
    .sign (op_sign),
    .mag  (op_mag)
  );

  i2d_lzc #(.W(INT_W), .CW(LZC_W)) u_lzc (
    .val (op_mag),
    .cnt (op_lz)
  );

  i2d_round u_round (
    .sign    (op_sign),
    .mag     (op_mag),
    .lz      (op_lz),
    .rmode   (in_rmode),
    .res     (rnd_res),
    .inexact (rnd_inexact),
    .is_zero (rnd_zero)
  );

  // next-state
  logic               vld_d;
  logic [INT_W-1:0]   res_d;
  logic [CLS_W-1:0]   cls_d;
  logic               xx_d;
  logic [3:0]         cr_d;
  logic               dat_en;

  always_comb begin
    vld_d  = in_valid;
    dat_en = in_valid;
    res_d  = rnd_res;
    xx_d   = rnd_inexact;
    if (rnd_zero)     cls_d = CLS_PZERO;
    else if (op_sign) cls_d = CLS_NNORM;
    else              cls_d = CLS_PNORM;
    // {FX, FEX, VX, OX}: only the summary bit can be raised by this operation
    cr_d = in_rec ? {rnd_inexact, 3'b000} : 4'b0000;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_result <= '0;
      out_class  <= CLS_PZERO;
      out_xx     <= 1'b0;
      out_fx     <= 1'b0;
      out_cr     <= '0;
    end else if (dat_en) begin
      out_result <= res_d;
      out_class  <= cls_d;
      out_xx     <= xx_d;
      out_fx     <= xx_d;
      out_cr     <= cr_d;
    end
  end
endmodule

// File: rtl/i2d_chk.sv
module i2d_chk
  import i2d_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [INT_W-1:0]   in_op,
  input logic [1:0]         in_rmode,
  input logic               in_rec,
  input logic               out_valid,
  input logic [INT_W-1:0]   out_result,
  input logic [CLS_W-1:0]   out_class,
  input logic               out_xx,
  input logic               out_fx,
  input logic [3:0]         out_cr
);
  logic [INT_W-1:0] c_mag;
  logic             c_small;
  always_comb begin
    c_mag   = in_op[INT_W-1] ? (~in_op + INT_W'(1)) : in_op;
    c_small = (c_mag <= (INT_W'(1) << SIG_W));
  end

  // R11
  lat_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R11
  lat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2
  exact_small_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && c_small) |=> !out_xx && !out_fx);
  // R3
  fx_tracks_xx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_fx == out_xx));
  // R9
  finite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_result[INT_W-2 -: EXP_W] != '1));
  // R7
  zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == '0) |=> (out_result == '0) && (out_class == CLS_PZERO));
  // R8
  sign_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_class) == 1) && (out_class[3] == out_result[INT_W-1]));
  // R10
  cr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_rec) |=> (out_cr == 4'b0000));
endmodule

bind int2dbl_conv i2d_chk u_chk (.*);

// File: tb/int2dbl_conv_tb.sv
module int2dbl_conv_tb;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_op;
  logic [1:0]  in_rmode;
  logic        in_rec;
  logic        out_valid;
  logic [63:0] out_result;
  logic [4:0]  out_class;
  logic        out_xx;
  logic        out_fx;
  logic [3:0]  out_cr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  int2dbl_conv u_dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    logic [63:0] res;
    logic [4:0]  cls;
    logic        xx;
    logic [3:0]  cr;
    string       tag;
  } exp_t;

  exp_t sb[$];

  function automatic void ref_conv(input logic [63:0] op, input logic [1:0] rm,
                                   output logic [63:0] res, output logic xx);
    logic s;
    logic [63:0] m, q, rem, half;
    int p, sh;
    logic up;
    s  = op[63];
    m  = s ? (~op + 64'd1) : op;
    xx = 1'b0;
    if (m == 64'd0) begin
      res = 64'd0;
      return;
    end
    p = 0;
    for (int i = 0; i < 64; i++) if (m[i]) p = i;
    if (p <= 52) begin
      q = m << (52 - p);
    end else begin
      sh   = p - 52;
      q    = m >> sh;
      rem  = m & ((64'd1 << sh) - 64'd1);
      half = 64'd1 << (sh - 1);
      xx   = (rem != 64'd0);
      case (rm)
        2'b00:   up = (rem > half) || (rem == half && q[0]);
        2'b01:   up = 1'b0;
        2'b10:   up = xx && !s;
        default: up = xx && s;
      endcase
      q = q + 64'(up);
      if (q == (64'd1 << 53)) begin
        q = 64'd1 << 52;
        p++;
      end
    end
    res = {s, 11'(1023 + p), q[51:0]};
  endfunction

  task automatic fail(string tag, string what, logic [63:0] act, logic [63:0] expv);
    n_bad++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
  endtask

  task automatic send(logic [63:0] op, logic [1:0] rm, logic rec, string tag);
    exp_t e;
    logic [63:0] r;
    logic x;
    ref_conv(op, rm, r, x);
    e.res = r;
    e.xx  = x;
    e.cls = (op == 64'd0) ? 5'b00010 : (op[63] ? 5'b01000 : 5'b00100);
    e.cr  = rec ? {x, 3'b000} : 4'b0000;
    e.tag = tag;
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = op;
    in_rmode = rm;
    in_rec   = rec;
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_op    = 64'hDEAD_BEEF_0BAD_F00D;
    end
  endtask

  task automatic all_modes(logic [63:0] op, string tag);
    for (int m = 0; m < 4; m++) send(op, 2'(m), 1'b1, tag);
  endtask

  // monitor
  logic iv_q = 1'b0;
  always @(posedge clk) iv_q <= in_valid;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid !== iv_q) begin
        n_cmp++;
        fail("R11", "out_valid", 64'(out_valid), 64'(iv_q));
      end
      if (out_valid) begin
        if (sb.size() == 0) begin
          n_cmp++;
          fail("R11", "unexpected result", out_result, 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          n_cmp++;
          if (out_result !== e.res) fail(e.tag, "result", out_result, e.res);
          else if (out_class !== e.cls) fail(e.tag, "class(R8)", 64'(out_class), 64'(e.cls));
          else if (out_xx !== e.xx) fail(e.tag, "xx(R3)", 64'(out_xx), 64'(e.xx));
          else if (out_fx !== e.xx) fail(e.tag, "fx(R3)", 64'(out_fx), 64'(e.xx));
          else if (out_cr !== e.cr) fail(e.tag, "cr(R10)", 64'(out_cr), 64'(e.cr));
        end
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=0 pending", sb.size());
      summary();
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_op    = '0;
    in_rmode = 2'b00;
    in_rec   = 1'b0;
    repeat (3) @(negedge clk);
    n_cmp++;
    if (out_valid !== 1'b0) fail("R12", "out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    idle(2);
    n_cmp++;
    if (out_valid !== 1'b0) fail("R12", "out_valid after reset", 64'(out_valid), 64'd0);

    // R7 zero
    send(64'd0, 2'b00, 1'b1, "R7");
    send(64'd0, 2'b11, 1'b0, "R7");
    // R1 / R8 small values
    send(64'd1, 2'b00, 1'b0, "R1");
    send(-64'sd1, 2'b00, 1'b1, "R8");
    send(64'd12345, 2'b10, 1'b0, "R1");
    send(-64'sd987654321, 2'b01, 1'b0, "R8");
    // R2 boundary of exactness
    all_modes(64'd1 << 53, "R2");
    all_modes(-(64'd1 << 53), "R2");
    all_modes((64'd1 << 53) - 64'd1, "R2");
    idle(2);
    // R4 / R3 first inexact values, tie and non-tie
    all_modes((64'd1 << 53) + 64'd1, "R4");
    all_modes(-((64'd1 << 53) + 64'd1), "R4");
    all_modes((64'd1 << 53) + 64'd3, "R4");
    all_modes((64'd1 << 60) + 64'd100, "R3");
    // R5 carry out of significand
    all_modes(64'h7FFF_FFFF_FFFF_FFFF, "R5");
    all_modes(-64'sh7FFF_FFFF_FFFF_FFFF, "R5");
    // R6 most negative
    all_modes(64'h8000_0000_0000_0000, "R6");
    // R10 record flag off with an inexact operand
    send(64'h0123_4567_89AB_CDEF, 2'b00, 1'b0, "R10");
    send(64'h0123_4567_89AB_CDEF, 2'b00, 1'b1, "R10");
    idle(3);

    // mixed random, varied magnitudes
    for (int k = 0; k < 400; k++) begin
      logic [63:0] v;
      v = {$urandom(), $urandom()};
      v = $signed(v) >>> ($urandom() % 64);
      send(v, 2'($urandom()), 1'($urandom()), "R1");
      if (($urandom() % 5) == 0) idle(1);
    end
    idle(4);

    // R6 direct value check at the port
    send(64'h8000_0000_0000_0000, 2'b10, 1'b0, "R6");
    idle(1);
    n_cmp++;
    if (out_result !== 64'hC3E0_0000_0000_0000)
      fail("R6", "direct", out_result, 64'hC3E0_0000_0000_0000);
    send(64'h7FFF_FFFF_FFFF_FFFF, 2'b00, 1'b0, "R5");
    idle(1);
    n_cmp++;
    if (out_result !== 64'h43E0_0000_0000_0000)
      fail("R5", "direct", out_result, 64'h43E0_0000_0000_0000);
    idle(3);

    n_cmp++;
    if (sb.size() != 0) fail("R11", "pending items", 64'(sb.size()), 64'd0);
    done = 1;
    summary();
    $finish;
  end
endmodule